// File: doc/BRIEF.md
# Random Memory Traffic Checker

This block drives pseudo-random single-byte reads and writes into a memory under test and checks what comes back. Each cycle it draws a candidate access from an internal xorshift generator: a read/write choice weighted by a programmable read percentage, a region choice weighted by a programmable uncached percentage (one uncached window or one of two cached windows), and a block-aligned offset to which a fixed tester number is added. Several copies with different tester numbers can therefore share blocks while each touches only its own byte lane.

A shadow byte array holds the contents the memory ought to have. A write updates the shadow when it is issued. A read latches the shadow byte as its expected value when it is issued, so the response can return any time later. An eight-entry table of in-flight accesses, searched in parallel, stops a second access to a busy address and supplies the tag carried by each response. A read response whose byte differs from its latched value sets a sticky mismatch flag. A run of cycles with no response sets a sticky stall flag. Completed reads drive a progress pulse and a done output.

Requests leave on a valid/ready channel. Once `req_valid` is high it stays high with its fields unchanged until `req_ready` is seen high at a clock edge, and no new candidate is drawn into the slot in the meantime. Responses arrive on a second valid/ready channel whose `rsp_ready` is always high: every response is taken in the cycle it is offered.

Top module: `mtc_traffic_checker`

## Requirements
- R1: Every access is a read when a draw scaled to 0..99 is below `cfg_read_pct` and a write otherwise (`req_write` = 1 for a write). A setting of 0 gives only writes and 100 gives only reads.
- R2: Every access goes to the uncached window at 0x800000 when a second 0..99 draw is below `cfg_uncache_pct`. Otherwise a random bit picks the window at 0x100000 or 0x400000. The offset from the window base is always below REGION_BYTES.
- R3: Every access is one byte wide. Its offset is a multiple of BLOCK_BYTES plus TESTER_ID, so `req_addr` modulo BLOCK_BYTES always equals TESTER_ID.
- R4: No request is issued to an address that is already in flight, and no tag in flight is issued again. At most TRACK_DEPTH (8) accesses are in flight; when all are in flight, no request is issued.
- R5: While `req_valid` is high and `req_ready` is low, the next cycle keeps `req_valid` high with `req_addr`, `req_write`, `req_wdata` and `req_tag` unchanged.
- R6: A read response (`rsp_valid`, with `rsp_tag` naming a read in flight) whose `rsp_rdata` differs from the shadow byte latched at issue sets `err_mismatch`. The flag stays set until reset. Correct data leaves it low.
- R7: Every response, read or write, frees its tag and address for reuse. The data of a write response is ignored.
- R8: A counter of consecutive cycles without a response restarts on every response. After STALL_LIMIT such cycles `err_deadlock` is set and stays set until reset. The counter holds while `done` is high.
- R9: `progress_pulse` is high for one cycle each time the number of completed reads reaches a multiple of a nonzero `cfg_progress_every`.
- R10: `done` is high exactly when `cfg_max_reads` is nonzero and completed reads are at least `cfg_max_reads`. After `done` rises, no new request is issued.
- R11: During reset `req_valid`, `err_mismatch`, `err_deadlock`, `progress_pulse` and `done` are low, and the shadow contents are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_read_pct | input | 7 | Percentage of reads, 0..100 |
| cfg_uncache_pct | input | 7 | Percentage of uncached accesses, 0..100 |
| cfg_progress_every | input | 16 | Reads between progress pulses, 0 disables |
| cfg_max_reads | input | 32 | Reads before done, 0 runs forever |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Memory accepts request |
| req_write | output | 1 | 1 write, 0 read |
| req_addr | output | 24 | Byte address |
| req_wdata | output | 8 | Write byte |
| req_tag | output | 3 | Table slot of this access |
| rsp_valid | input | 1 | Response valid |
| rsp_ready | output | 1 | Always 1 |
| rsp_tag | input | 3 | Tag of the completed access |
| rsp_rdata | input | 8 | Read byte |
| err_mismatch | output | 1 | Sticky read-data error |
| err_deadlock | output | 1 | Sticky stall error |
| progress_pulse | output | 1 | One-cycle progress marker |
| done | output | 1 | Read quota reached |

## Verification
Some behaviours are checked by assertions on every cycle. These are: the request is held unchanged under back-pressure, every issued address lies in a legal window on the tester's byte lane, both error flags stay set once set, and no new request appears once `done` is high. Other behaviours can only be shown by the bench scenarios, because they need a memory model and knowledge of the whole run. These are: the read/write and region percentages at their extremes, the absence of duplicate in-flight addresses, the table filling up with no responses, the reuse of tags, a corrupted read being caught, the stall flag rising near its limit, and the progress and done counts matching the number of reads actually completed.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  localparam int ADDR_W = 24;

  localparam logic [ADDR_W-1:0] BASE_CA = 24'h100000;
  localparam logic [ADDR_W-1:0] BASE_CB = 24'h400000;
  localparam logic [ADDR_W-1:0] BASE_UC = 24'h800000;

  typedef enum logic [1:0] {
    RG_CACHED_A = 2'd0,
    RG_CACHED_B = 2'd1,
    RG_UNCACHED = 2'd2
  } region_e;

  typedef struct packed {
    logic              wr;
    region_e           rg;
    logic [7:0]        data;
    logic [ADDR_W-1:0] addr;
  } cand_t;

  // Maps an 8-bit random byte onto 0..99 with near-uniform spread.
  function automatic logic [6:0] scale_pct(input logic [7:0] r);
    logic [15:0] prod;
    prod = {8'd0, r} * 16'd100;
    return prod[14:8];
  endfunction
endpackage

// File: rtl/mtc_rng.sv
module mtc_rng #(
  parameter logic [31:0] SEED = 32'h1234_5679
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] rnd
);
  logic [31:0] s1, s2, s3;

  always_comb begin
    s1 = rnd ^ (rnd << 13);
    s2 = s1 ^ (s1 >> 17);
    s3 = s2 ^ (s2 << 5);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rnd <= (SEED == 32'd0) ? 32'h1 : SEED;
    else        rnd <= s3;
  end
endmodule

// File: rtl/mtc_gen.sv
module mtc_gen
  import mtc_pkg::*;
#(
  parameter int TESTER_ID    = 0,
  parameter int BLOCK_BYTES  = 16,
  parameter int REGION_BYTES = 64,
  localparam int OFF_W       = $clog2(REGION_BYTES)
) (
  input  logic [31:0]      rnd,
  input  logic [6:0]       read_pct,
  input  logic [6:0]       unc_pct,
  output cand_t            cand,
  output logic [OFF_W-1:0] offset
);
  localparam logic [OFF_W-1:0] BLK_MASK = OFF_W'(BLOCK_BYTES - 1);

  logic [6:0]       cmd_draw, unc_draw;
  logic [OFF_W-1:0] off_raw;
  logic [ADDR_W-1:0] base;

  always_comb begin
    cmd_draw = scale_pct(rnd[7:0]);
    unc_draw = scale_pct(rnd[15:8]);
    off_raw  = rnd[17 +: OFF_W];
    offset   = (off_raw & ~BLK_MASK) + OFF_W'(TESTER_ID);

    cand.wr   = !(cmd_draw < read_pct);
    cand.data = rnd[31:24] ^ {1'b0, rnd[23:17]};
    if (unc_draw < unc_pct)  cand.rg = RG_UNCACHED;
    else if (rnd[16])        cand.rg = RG_CACHED_A;
    else                     cand.rg = RG_CACHED_B;

    unique case (cand.rg)
      RG_CACHED_A: base = BASE_CA;
      RG_CACHED_B: base = BASE_CB;
      default:     base = BASE_UC;
    endcase
    cand.addr = base + ADDR_W'(offset);
  end
endmodule

// File: rtl/mtc_shadow.sv
module mtc_shadow #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [7:0] mem [ENTRIES];

  assign rd_data = mem[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= 8'd0;
    end else if (wr_en) begin
      mem[idx] <= wr_data;
    end
  end
endmodule

// File: rtl/mtc_track.sv
module mtc_track #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 24,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              hit,
  output logic              full,
  output logic [TAG_W-1:0]  free_tag,
  input  logic              alloc_en,
  input  logic              alloc_rd,
  input  logic [7:0]        alloc_exp,
  input  logic [TAG_W-1:0]  rel_tag,
  input  logic              rel_en,
  output logic              ent_vld,
  output logic              ent_rd,
  output logic [7:0]        ent_exp
);
  logic [DEPTH-1:0]  vld, rd, match;
  logic [7:0]        exp_q  [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign match[g] = vld[g] && (addr_q[g] == look_addr);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[g]    <= 1'b0;
        rd[g]     <= 1'b0;
        exp_q[g]  <= 8'd0;
        addr_q[g] <= '0;
      end else if (alloc_en && free_tag == TAG_W'(g)) begin
        vld[g]    <= 1'b1;
        rd[g]     <= alloc_rd;
        exp_q[g]  <= alloc_exp;
        addr_q[g] <= look_addr;
      end else if (rel_en && rel_tag == TAG_W'(g)) begin
        vld[g]    <= 1'b0;
      end
    end
  end

  always_comb begin
    free_tag = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld[i]) free_tag = TAG_W'(i);
    end
  end

  assign hit     = |match;
  assign full    = &vld;
  assign ent_vld = vld[rel_tag];
  assign ent_rd  = rd[rel_tag];
  assign ent_exp = exp_q[rel_tag];
endmodule

// File: rtl/mtc_traffic_checker.sv
module mtc_traffic_checker
  import mtc_pkg::*;
#(
  parameter int          TESTER_ID    = 0,
  parameter int          BLOCK_BYTES  = 16,
  parameter int          REGION_BYTES = 64,
  parameter int          TRACK_DEPTH  = 8,
  parameter int          STALL_LIMIT  = 500000,
  parameter logic [31:0] SEED         = 32'h1234_5679
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [6:0]  cfg_read_pct,
  input  logic [6:0]  cfg_uncache_pct,
  input  logic [15:0] cfg_progress_every,
  input  logic [31:0] cfg_max_reads,
  output logic        req_valid,
  input  logic        req_ready,
  output logic        req_write,
  output logic [23:0] req_addr,
  output logic [7:0]  req_wdata,
  output logic [2:0]  req_tag,
  input  logic        rsp_valid,
  output logic        rsp_ready,
  input  logic [2:0]  rsp_tag,
  input  logic [7:0]  rsp_rdata,
  output logic        err_mismatch,
  output logic        err_deadlock,
  output logic        progress_pulse,
  output logic        done
);
  localparam int OFF_W  = $clog2(REGION_BYTES);
  localparam int IDX_W  = OFF_W + 2;
  localparam int TAG_W  = $clog2(TRACK_DEPTH);
  localparam int IDLE_W = $clog2(STALL_LIMIT + 1);

  logic [31:0]      rnd;
  cand_t            cand;
  logic [OFF_W-1:0] cand_off;
  logic             hit, full, issue;
  logic [TAG_W-1:0] free_tag;
  logic [7:0]       shadow_byte;
  logic             ent_vld, ent_rd, rel_en, read_done;
  logic [7:0]       ent_exp;
  logic [31:0]      rd_cnt;
  logic [15:0]      prog_cnt;
  logic [IDLE_W-1:0] idle_cnt;

  mtc_rng #(.SEED(SEED)) u_rng (
    .clk(clk), .rst_n(rst_n), .rnd(rnd)
  );

  mtc_gen #(
    .TESTER_ID(TESTER_ID), .BLOCK_BYTES(BLOCK_BYTES), .REGION_BYTES(REGION_BYTES)
  ) u_gen (
    .rnd(rnd), .read_pct(cfg_read_pct), .unc_pct(cfg_uncache_pct),
    .cand(cand), .offset(cand_off)
  );

  // Slot is free when empty or emptied this cycle; a held request blocks drawing.
  assign issue = (!req_valid || req_ready) && !done && !hit && !full;

  mtc_shadow #(.IDX_W(IDX_W)) u_shadow (
    .clk(clk), .rst_n(rst_n),
    .wr_en(issue && cand.wr),
    .idx({cand.rg, cand_off}),
    .wr_data(cand.data),
    .rd_data(shadow_byte)
  );

  assign rel_en    = rsp_valid && ent_vld;
  assign read_done = rel_en && ent_rd;

  mtc_track #(.DEPTH(TRACK_DEPTH), .ADDR_W(ADDR_W)) u_track (
    .clk(clk), .rst_n(rst_n),
    .look_addr(cand.addr), .hit(hit), .full(full), .free_tag(free_tag),
    .alloc_en(issue), .alloc_rd(!cand.wr), .alloc_exp(shadow_byte),
    .rel_tag(TAG_W'(rsp_tag)), .rel_en(rel_en),
    .ent_vld(ent_vld), .ent_rd(ent_rd), .ent_exp(ent_exp)
  );

  // Request slot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      req_tag   <= '0;
    end else if (issue) begin
      req_valid <= 1'b1;
      req_write <= cand.wr;
      req_addr  <= cand.addr;
      req_wdata <= cand.data;
      req_tag   <= 3'(free_tag);
    end else if (req_ready) begin
      req_valid <= 1'b0;
    end
  end

  assign rsp_ready = 1'b1;
  assign done      = (cfg_max_reads != 32'd0) && (rd_cnt >= cfg_max_reads);

  // Read accounting, progress and data check
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_cnt         <= '0;
      prog_cnt       <= '0;
      progress_pulse <= 1'b0;
      err_mismatch   <= 1'b0;
    end else begin
      progress_pulse <= 1'b0;
      if (read_done) begin
        rd_cnt <= rd_cnt + 32'd1;
        if (rsp_rdata != ent_exp) err_mismatch <= 1'b1;
        if (cfg_progress_every != 16'd0 && (prog_cnt + 16'd1) >= cfg_progress_every) begin
          prog_cnt       <= '0;
          progress_pulse <= 1'b1;
        end else begin
          prog_cnt <= prog_cnt + 16'd1;
        end
      end
    end
  end

  // Stall watchdog
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_cnt     <= '0;
      err_deadlock <= 1'b0;
    end else if (rsp_valid) begin
      idle_cnt <= '0;
    end else if (!done && idle_cnt != IDLE_W'(STALL_LIMIT)) begin
      idle_cnt <= idle_cnt + 1'b1;
      if (idle_cnt == IDLE_W'(STALL_LIMIT - 1)) err_deadlock <= 1'b1;
    end
  end
endmodule

// File: rtl/mtc_traffic_checker_sva.sv
module mtc_traffic_checker_sva #(
  parameter int TESTER_ID    = 0,
  parameter int BLOCK_BYTES  = 16,
  parameter int REGION_BYTES = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [23:0] req_addr,
  input logic [7:0]  req_wdata,
  input logic [2:0]  req_tag,
  input logic        err_mismatch,
  input logic        err_deadlock,
  input logic        done
);
  localparam int BLK_W = $clog2(BLOCK_BYTES);

  logic in_window;
  always_comb begin
    in_window = ((req_addr >= 24'h100000) && (req_addr < 24'h100000 + 24'(REGION_BYTES))) ||
                ((req_addr >= 24'h400000) && (req_addr < 24'h400000 + 24'(REGION_BYTES))) ||
                ((req_addr >= 24'h800000) && (req_addr < 24'h800000 + 24'(REGION_BYTES)));
  end

  a_r5_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write) &&
                                $stable(req_wdata) && $stable(req_tag));

  a_r3_byte_lane: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[BLK_W-1:0] == BLK_W'(TESTER_ID));

  a_r2_window: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> in_window);

  a_r6_mismatch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_mismatch |=> err_mismatch);

  a_r8_deadlock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_deadlock |=> err_deadlock);

  a_r10_no_issue_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done && !req_valid |=> !req_valid);
endmodule

bind mtc_traffic_checker mtc_traffic_checker_sva #(
  .TESTER_ID(TESTER_ID), .BLOCK_BYTES(BLOCK_BYTES), .REGION_BYTES(REGION_BYTES)
) u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_tag(req_tag),
  .err_mismatch(err_mismatch), .err_deadlock(err_deadlock), .done(done)
);

// File: tb/mtc_traffic_checker_tb_top.sv
`timescale 1ns/1ps
module mtc_traffic_checker_tb_top;
  localparam int TID   = 3;
  localparam int BLK   = 16;
  localparam int RGN   = 64;
  localparam int LIMIT = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  cfg_read_pct = 7'd50;
  logic [6:0]  cfg_uncache_pct = 7'd30;
  logic [15:0] cfg_progress_every = 16'd0;
  logic [31:0] cfg_max_reads = 32'd0;
  logic        req_valid, req_write, rsp_ready;
  logic        req_ready = 1'b0;
  logic [23:0] req_addr;
  logic [7:0]  req_wdata;
  logic [2:0]  req_tag;
  logic        rsp_valid = 1'b0;
  logic [2:0]  rsp_tag = 3'd0;
  logic [7:0]  rsp_rdata = 8'd0;
  logic        err_mismatch, err_deadlock, progress_pulse, done;

  always #2.5 clk = ~clk;

  mtc_traffic_checker #(
    .TESTER_ID(TID), .BLOCK_BYTES(BLK), .REGION_BYTES(RGN),
    .TRACK_DEPTH(8), .STALL_LIMIT(LIMIT), .SEED(32'hACE1_2461)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_read_pct(cfg_read_pct), .cfg_uncache_pct(cfg_uncache_pct),
    .cfg_progress_every(cfg_progress_every), .cfg_max_reads(cfg_max_reads),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tag(rsp_tag), .rsp_rdata(rsp_rdata),
    .err_mismatch(err_mismatch), .err_deadlock(err_deadlock),
    .progress_pulse(progress_pulse), .done(done)
  );

  int nchk = 0;
  int nerr = 0;

  // Memory model and in-flight view
  logic [7:0]  mem [int];
  logic        pend_v [8];
  logic [23:0] pend_a [8];
  logic        pend_w [8];
  int          pend_age [8];

  int acc_cnt, rd_iss, wr_iss, uc_cnt, rd_done, pulse_cnt, inj_cnt;
  int v_region, v_lane, v_dup, v_hold, v_done, v_stop;
  logic        last_rsp_rd, prev_stall, prev_done, prev_valid, prev_acc;
  logic [23:0] s_addr;
  logic [7:0]  s_wdata;
  logic        s_write;
  logic [2:0]  s_tag;

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_state();
    mem.delete();
    for (int i = 0; i < 8; i++) begin pend_v[i] = 1'b0; pend_age[i] = 0; end
    acc_cnt = 0; rd_iss = 0; wr_iss = 0; uc_cnt = 0; rd_done = 0; pulse_cnt = 0; inj_cnt = 0;
    v_region = 0; v_lane = 0; v_dup = 0; v_hold = 0; v_done = 0; v_stop = 0;
    last_rsp_rd = 1'b0; prev_stall = 1'b0; prev_done = 1'b0; prev_valid = 1'b0; prev_acc = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_ready = 1'b0; rsp_valid = 1'b0;
    clear_state();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [7:0] mem_rd(input logic [23:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 8'd0;
  endfunction

  // One negedge per cycle: observe, accept, respond.
  task automatic run(input int cycles, input int ready_pct, input bit rsp_en, input bit inject);
    for (int c = 0; c < cycles; c++) begin
      logic rdy, is_new, in_win;
      int start;
      @(negedge clk);
      if (rsp_valid && last_rsp_rd) rd_done++;
      if (done !== ((cfg_max_reads != 0) && (rd_done >= int'(cfg_max_reads)))) v_done++;
      if (progress_pulse) pulse_cnt++;
      if (prev_stall && !(req_valid && req_addr == s_addr && req_write == s_write &&
                          req_wdata == s_wdata && req_tag == s_tag)) v_hold++;
      is_new = req_valid && (!prev_valid || prev_acc);
      if (is_new && prev_done) v_stop++;
      prev_done = done;
      rdy = (($urandom % 100) < ready_pct);
      req_ready = rdy;
      prev_acc = req_valid && rdy;
      if (req_valid && rdy) begin
        in_win = ((req_addr - 24'h100000) < RGN) || ((req_addr - 24'h400000) < RGN) ||
                 ((req_addr - 24'h800000) < RGN);
        if (!in_win) v_region++;
        if ((req_addr % BLK) != TID) v_lane++;
        if (pend_v[req_tag]) v_dup++;
        for (int i = 0; i < 8; i++) if (pend_v[i] && pend_a[i] == req_addr) v_dup++;
        pend_v[req_tag] = 1'b1; pend_a[req_tag] = req_addr;
        pend_w[req_tag] = req_write; pend_age[req_tag] = 0;
        if (req_write) begin mem[int'(req_addr)] = req_wdata; wr_iss++; end
        else rd_iss++;
        if ((req_addr - 24'h800000) < RGN) uc_cnt++;
        acc_cnt++;
      end
      prev_stall = req_valid && !rdy;
      prev_valid = req_valid;
      s_addr = req_addr; s_write = req_write; s_wdata = req_wdata; s_tag = req_tag;
      rsp_valid = 1'b0; last_rsp_rd = 1'b0;
      if (rsp_en && ($urandom % 100) < 60) begin
        start = $urandom % 8;
        for (int k = 0; k < 8; k++) begin
          int t;
          t = (start + k) % 8;
          if (!rsp_valid && pend_v[t] && pend_age[t] >= 1) begin
            rsp_valid = 1'b1; rsp_tag = 3'(t);
            if (pend_w[t]) rsp_rdata = 8'($urandom);
            else begin
              rsp_rdata = mem_rd(pend_a[t]);
              if (inject) begin rsp_rdata = rsp_rdata ^ 8'h5A; inj_cnt++; end
            end
            last_rsp_rd = !pend_w[t];
            pend_v[t] = 1'b0;
          end
        end
      end
      for (int i = 0; i < 8; i++) if (pend_v[i]) pend_age[i]++;
    end
  endtask

  task automatic drain();
    req_ready = 1'b0;
    run(40, 0, 1'b1, 1'b0);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 req_valid in reset", req_valid, 0);
    chk("R11 err_mismatch in reset", err_mismatch, 0);
    chk("R11 err_deadlock in reset", err_deadlock, 0);
    chk("R11 done/progress in reset", {done, progress_pulse}, 0);
  endtask

  task automatic t_mixed();
    cfg_read_pct = 7'd50; cfg_uncache_pct = 7'd30; cfg_progress_every = 16'd7; cfg_max_reads = 0;
    do_reset();
    run(3000, 70, 1'b1, 1'b0);
    chk("R6 no mismatch on correct data", err_mismatch, 0);
    chk("R5 held under stall", v_hold, 0);
    chk("R4 no duplicate address or tag", v_dup, 0);
    chk("R2 window", v_region, 0);
    chk("R3 byte lane", v_lane, 0);
    chk("R7 tags reused", acc_cnt > 8, 1);
    chk("R1 both kinds issued", (rd_iss > 0) && (wr_iss > 0), 1);
    chk("R9 pulses vs reads", pulse_cnt, rd_done / 7);
    chk("R8 no stall flag with traffic", err_deadlock, 0);
    chk("R10 done low with zero quota", v_done, 0);
  endtask

  task automatic t_writes_only();
    cfg_read_pct = 7'd0; cfg_uncache_pct = 7'd100; cfg_progress_every = 0; cfg_max_reads = 0;
    do_reset();
    run(400, 80, 1'b1, 1'b0);
    chk("R1 read_pct 0 gives no reads", rd_iss, 0);
    chk("R2 uncache 100 all in uncached window", uc_cnt, acc_cnt);
    chk("R1 writes flowed", acc_cnt > 20, 1);
  endtask

  task automatic t_reads_only();
    cfg_read_pct = 7'd100; cfg_uncache_pct = 7'd0; cfg_progress_every = 0; cfg_max_reads = 0;
    do_reset();
    run(400, 80, 1'b1, 1'b0);
    chk("R1 read_pct 100 gives no writes", wr_iss, 0);
    chk("R2 uncache 0 none uncached", uc_cnt, 0);
    chk("R11 zeroed shadow matches empty memory", err_mismatch, 0);
  endtask

  task automatic t_inject();
    cfg_read_pct = 7'd60; cfg_uncache_pct = 7'd20; cfg_progress_every = 0; cfg_max_reads = 0;
    do_reset();
    run(200, 90, 1'b1, 1'b0);
    chk("R6 clean before corruption", err_mismatch, 0);
    run(200, 90, 1'b1, 1'b1);
    chk("R6 corruption injected", inj_cnt > 0, 1);
    drain();
    chk("R6 mismatch flagged and sticky", err_mismatch, 1);
  endtask

  task automatic t_stall();
    cfg_read_pct = 7'd50; cfg_uncache_pct = 7'd30; cfg_progress_every = 0; cfg_max_reads = 0;
    do_reset();
    run(60, 100, 1'b0, 1'b0);
    chk("R4 table full caps accepts at 8", acc_cnt, 8);
    chk("R4 no request while full", req_valid, 0);
    run(LIMIT - 60 - 40, 100, 1'b0, 1'b0);
    chk("R8 no flag before limit", err_deadlock, 0);
    run(80, 100, 1'b0, 1'b0);
    chk("R8 flag after limit", err_deadlock, 1);
    run(20, 100, 1'b1, 1'b0);
    chk("R8 flag sticky after responses", err_deadlock, 1);
  endtask

  task automatic t_quota();
    cfg_read_pct = 7'd70; cfg_uncache_pct = 7'd10; cfg_progress_every = 16'd5; cfg_max_reads = 32'd23;
    do_reset();
    run(1500, 75, 1'b1, 1'b0);
    chk("R10 done raised", done, 1);
    chk("R10 done tracks read count", v_done, 0);
    chk("R10 no new request after done", v_stop, 0);
    chk("R10 quota reached", rd_done >= 23, 1);
    chk("R9 progress pulses", pulse_cnt, rd_done / 5);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_mixed();
        t_writes_only();
        t_reads_only();
        t_inject();
        t_stall();
        t_quota();
      end
      begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule